// File: doc/BRIEF.md
# Quad PWM Generator with Pair Joining

This block produces up to four pulse-width modulated outputs. Each channel holds an 8-bit period and an 8-bit duty value. Its counter advances on the tick of a clock source chosen per channel. The output is high from the start of each period until the count reaches the duty value, then low until the period ends. Period and duty inputs are copied into working registers only at a period boundary or while the channel is disabled, so a new setting never produces a torn cycle.

Three tick sources are shared by all channels. Sources A and B each divide the system clock by a power of two. Source S divides source A further by twice an 8-bit scale value. A pair of neighbouring channels can be joined into one 16-bit channel for finer resolution. The lower-numbered channel of the pair then supplies the upper byte and the higher-numbered channel supplies the lower byte. The joined output appears on the higher-numbered pin.

Top module: `pwm_quad`

## Requirements
- R1: With period P and duty D (D < P), an enabled channel's output is high for D ticks and low for P−D ticks in every period; D = 0 gives a constant low output.
- R2: When D ≥ P (including D = P) the enabled channel's output stays high continuously.
- R3: While a channel's enable is low its output is low and its counter is held at zero; after enable rises the output is high at once and stays high for D ticks of the fresh period.
- R4: Period and duty inputs written while a channel runs change nothing until the current period ends; while disabled, the inputs are taken continuously.
- R5: Source A ticks once every 2^preSelA system clocks and source B once every 2^preSelB clocks (select values 0 to 7); with a select of 0 the source ticks on every clock.
- R6: Source S ticks once every 2·N ticks of source A, where N is scaleN, and N = 0 stands for 256; S never ticks on two consecutive clocks.
- R7: Each channel's 2-bit field chSrc[2c+1:2c] selects its source: 00 = A, 01 = B, 10 or 11 = S.
- R8: Setting joinPair[p] joins channels 2p and 2p+1 into a 16-bit channel with period {period byte 2p, period byte 2p+1} and duty formed the same way. The output is on pin 2p+1 and pin 2p stays low. The channel runs under the enable and source field of channel 2p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEn | input | 4 | Per-channel enable |
| chSrc | input | 8 | Per-channel tick source field, two bits per channel |
| joinPair | input | 2 | Per-pair 16-bit join control |
| preSelA | input | 3 | Power-of-two divide exponent for source A |
| preSelB | input | 3 | Power-of-two divide exponent for source B |
| scaleN | input | 8 | Further divider for source S (0 means 256) |
| period | input | 32 | Period bytes, byte c for channel c |
| duty | input | 32 | Duty bytes, byte c for channel c |
| pwmOut | output | 4 | PWM outputs |

## Verification
The hardest case to reach from the ports is a write that lands part-way through a running period. Its effect differs from the correct behaviour only until the next boundary. The stimulus therefore synchronises to a rising output edge, rewrites duty and period a few clocks later, and samples the output where the old and the new duty disagree. A second hard case is a restart with a nonzero count. The channel is disabled mid-period and re-enabled, and the length of the first high phase shows whether the count was cleared. The scaled source with N = 0 needs about a thousand clocks per period, and the bench waits for it in full.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int PWM_CH = 4;

  // strobes from the control (tick generation) to the datapath (counters)
  typedef struct packed {
    logic [PWM_CH-1:0] chTick;
    logic [PWM_CH-1:0] chClr;
    logic              tickA;
    logic              tickB;
    logic              tickS;
  } pwmStb_t;
endpackage

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NCH = PWM_CH,
  parameter int PSW = 3,
  parameter int SCW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   chEn,
  input  logic [2*NCH-1:0] chSrc,
  input  logic [NCH/2-1:0] joinPair,
  input  logic [PSW-1:0]   preSelA,
  input  logic [PSW-1:0]   preSelB,
  input  logic [SCW-1:0]   scaleN,
  output pwmStb_t          stb
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [DIVW-1:0] divCnt;
  logic [DIVW-1:0] maskA;
  logic [DIVW-1:0] maskB;
  logic [SCW:0]    sCnt;
  logic [SCW:0]    sLimit;
  logic            tickA;
  logic            tickB;
  logic            tickS;
  logic [NCH-1:0]  tickV;
  logic [NCH-1:0]  clrV;

  assign maskA  = ~({DIVW{1'b1}} << preSelA);
  assign maskB  = ~({DIVW{1'b1}} << preSelB);
  assign tickA  = (divCnt & maskA) == maskA;
  assign tickB  = (divCnt & maskB) == maskB;
  assign sLimit = (scaleN == '0) ? '1 : ({scaleN, 1'b0} - (SCW+1)'(1));
  assign tickS  = tickA && (sCnt == sLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sCnt   <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (tickA) sCnt <= tickS ? '0 : sCnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    localparam int GOV = (c / 2) * 2 + 1;
    logic       joined;
    logic [1:0] src;
    logic       en;
    assign joined = joinPair[c/2];
    assign src    = joined ? chSrc[GOV*2 +: 2] : chSrc[c*2 +: 2];
    assign en     = joined ? chEn[GOV] : chEn[c];
    always_comb begin
      case (src)
        2'b00:   tickV[c] = tickA;
        2'b01:   tickV[c] = tickB;
        default: tickV[c] = tickS;
      endcase
    end
    assign clrV[c] = !en;
  end

  always_comb begin
    stb.chTick = tickV;
    stb.chClr  = clrV;
    stb.tickA  = tickA;
    stb.tickB  = tickB;
    stb.tickS  = tickS;
  end
endmodule

// File: rtl/pwm_quad_dp.sv
module pwm_quad_dp
  import pwm_quad_pkg::*;
#(
  parameter int NCH = PWM_CH,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStb_t           stb,
  input  logic [NCH/2-1:0]  joinPair,
  input  logic [NCH*CW-1:0] perIn,
  input  logic [NCH*CW-1:0] dutyIn,
  output logic [NCH-1:0]    pwmOut
);
  localparam int NPAIR = NCH / 2;
  localparam int DW    = 2 * CW;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int HI = 2 * p;
    localparam int LO = 2 * p + 1;

    logic [CW-1:0] cntH, cntL, perH, perL, dutH, dutL;
    logic [CW-1:0] inPerH, inPerL, inDutH, inDutL;
    logic [CW:0]   nxtH, nxtL;
    logic [DW:0]   nxtW;
    logic [DW-1:0] cntW, perW, dutW;
    logic          endH, endL, endW, joined;

    assign inPerH = perIn[HI*CW +: CW];
    assign inPerL = perIn[LO*CW +: CW];
    assign inDutH = dutyIn[HI*CW +: CW];
    assign inDutL = dutyIn[LO*CW +: CW];
    assign joined = joinPair[p];

    assign cntW = {cntH, cntL};
    assign perW = {perH, perL};
    assign dutW = {dutH, dutL};
    assign nxtH = {1'b0, cntH} + (CW+1)'(1);
    assign nxtL = {1'b0, cntL} + (CW+1)'(1);
    assign nxtW = {1'b0, cntW} + (DW+1)'(1);
    assign endH = nxtH >= {1'b0, perH};
    assign endL = nxtL >= {1'b0, perL};
    assign endW = nxtW >= {1'b0, perW};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntH <= '0; cntL <= '0;
        perH <= '0; perL <= '0;
        dutH <= '0; dutL <= '0;
      end else if (joined) begin
        if (stb.chClr[LO] || (stb.chTick[LO] && endW)) begin
          cntH <= '0; cntL <= '0;
          perH <= inPerH; perL <= inPerL;
          dutH <= inDutH; dutL <= inDutL;
        end else if (stb.chTick[LO]) begin
          {cntH, cntL} <= nxtW[DW-1:0];
        end
      end else begin
        if (stb.chClr[HI] || (stb.chTick[HI] && endH)) begin
          cntH <= '0;
          perH <= inPerH;
          dutH <= inDutH;
        end else if (stb.chTick[HI]) begin
          cntH <= nxtH[CW-1:0];
        end
        if (stb.chClr[LO] || (stb.chTick[LO] && endL)) begin
          cntL <= '0;
          perL <= inPerL;
          dutL <= inDutL;
        end else if (stb.chTick[LO]) begin
          cntL <= nxtL[CW-1:0];
        end
      end
    end

    assign pwmOut[HI] = !joined && !stb.chClr[HI] && ((dutH >= perH) || (cntH < dutH));
    assign pwmOut[LO] = !stb.chClr[LO] &&
                        (joined ? ((dutW >= perW) || (cntW < dutW))
                                : ((dutL >= perL) || (cntL < dutL)));
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH = PWM_CH,
  parameter int CW  = 8,
  parameter int PSW = 3,
  parameter int SCW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    chEn,
  input  logic [2*NCH-1:0]  chSrc,
  input  logic [NCH/2-1:0]  joinPair,
  input  logic [PSW-1:0]    preSelA,
  input  logic [PSW-1:0]    preSelB,
  input  logic [SCW-1:0]    scaleN,
  input  logic [NCH*CW-1:0] period,
  input  logic [NCH*CW-1:0] duty,
  output logic [NCH-1:0]    pwmOut
);
  pwmStb_t stb;

  pwm_quad_ctrl #(.NCH(NCH), .PSW(PSW), .SCW(SCW)) u_ctrl (
    .clk(clk), .rstN(rstN), .chEn(chEn), .chSrc(chSrc), .joinPair(joinPair),
    .preSelA(preSelA), .preSelB(preSelB), .scaleN(scaleN), .stb(stb)
  );

  pwm_quad_dp #(.NCH(NCH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .joinPair(joinPair),
    .perIn(period), .dutyIn(duty), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NCH = PWM_CH,
  parameter int CW  = 8,
  parameter int PSW = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    chEn,
  input logic [NCH/2-1:0]  joinPair,
  input logic [PSW-1:0]    preSelA,
  input logic [NCH*CW-1:0] duty,
  input pwmStb_t           stb,
  input logic [NCH-1:0]    pwmOut
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3: a disabled channel never drives its pin high
    assert_off_low_R3: assert property (@(posedge clk) disable iff (!rstN)
      !chEn[i] |-> !pwmOut[i]);
    // R3: a restart begins at count zero, so a nonzero duty gives a high output at once
    assert_restart_high_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $rose(chEn[i]) && !joinPair[i/2] && ($past(duty[i*CW +: CW]) != '0))
      |-> pwmOut[i]);
  end

  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    // R8: the upper-byte pin of a joined pair stays low
    assert_join_pin_low_R8: assert property (@(posedge clk) disable iff (!rstN)
      joinPair[p] |-> !pwmOut[2*p]);
  end

  // R5: a zero exponent makes source A tick on every clock
  assert_a_every_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (preSelA == '0) |-> stb.tickA);
  // R6: source S never ticks on two clocks in a row
  assert_s_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.tickS |=> !stb.tickS);
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_chk (
  .clk(clk), .rstN(rstN), .chEn(chEn), .joinPair(joinPair), .preSelA(preSelA),
  .duty(duty), .stb(stb), .pwmOut(pwmOut)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCH-1:0]    chEn = '0;
  logic [2*NCH-1:0]  chSrc = '0;
  logic [NCH/2-1:0]  joinPair = '0;
  logic [2:0]        preSelA = '0;
  logic [2:0]        preSelB = '0;
  logic [7:0]        scaleN = 8'd1;
  logic [NCH*CW-1:0] period = '0;
  logic [NCH*CW-1:0] duty = '0;
  logic [NCH-1:0]    pwmOut;

  pwm_quad dut (
    .clk(clk), .rstN(rstN), .chEn(chEn), .chSrc(chSrc), .joinPair(joinPair),
    .preSelA(preSelA), .preSelB(preSelB), .scaleN(scaleN), .period(period),
    .duty(duty), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    ch;
    int    hiLen;
    int    perLen;
    string req;
  } expItem_t;

  expItem_t sb[$];
  int  vecs = 0;
  int  bad  = 0;
  bit  done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRise(int ch);
    logic prev;
    prev = pwmOut[ch];
    while (1) begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) break;
      prev = pwmOut[ch];
    end
  endtask

  // driver side: queue the expected high time and period, wait until consumed
  task automatic expectWave(int ch, int hiLen, int perLen, string req);
    expItem_t e;
    e.ch = ch; e.hiLen = hiLen; e.perLen = perLen; e.req = req;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic setChan(int ch, logic [1:0] src, int per, int dty);
    @(negedge clk);
    chEn[ch] = 1'b0;
    chSrc[ch*2 +: 2] = src;
    period[ch*CW +: CW] = CW'(per);
    duty[ch*CW +: CW] = CW'(dty);
    @(negedge clk);
    chEn[ch] = 1'b1;
  endtask

  // monitor: skip one (possibly partial) period, then measure a full one
  initial begin
    expItem_t e;
    int h;
    int l;
    forever begin
      wait (sb.size() != 0);
      e = sb[0];
      waitRise(e.ch);
      waitRise(e.ch);
      h = 0;
      while (pwmOut[e.ch]) begin h++; @(negedge clk); end
      l = 0;
      while (!pwmOut[e.ch]) begin l++; @(negedge clk); end
      check(h == e.hiLen, {e.req, " high length"}, h, e.hiLen);
      check(h + l == e.perLen, {e.req, " period length"}, h + l, e.perLen);
      void'(sb.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int h;
    bit allOk;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == '0, "R3 reset outputs low", int'(pwmOut), 0);

    // R1 / R5: source A at full rate, then divided by 4
    setChan(0, 2'b00, 10, 3);
    expectWave(0, 3, 10, "R1 src A /1");
    preSelA = 3'd2;
    setChan(0, 2'b00, 6, 4);
    expectWave(0, 16, 24, "R5 src A /4");
    preSelA = 3'd0;

    // R7 / R5: source B divided by 2 on channel 2
    preSelB = 3'd1;
    setChan(2, 2'b01, 8, 1);
    expectWave(2, 2, 16, "R7 src B /2");

    // R6 / R7: source S, code 10 with N=2 and code 11 with N=0 (256)
    scaleN = 8'd2;
    setChan(1, 2'b10, 5, 2);
    expectWave(1, 8, 20, "R6 src S N=2");
    scaleN = 8'd0;
    setChan(1, 2'b11, 2, 1);
    expectWave(1, 512, 1024, "R6 src S N=0");

    // R2: duty equal to period holds the output high
    setChan(3, 2'b00, 5, 5);
    allOk = 1;
    repeat (30) begin @(negedge clk); if (!pwmOut[3]) allOk = 0; end
    check(allOk, "R2 duty equals period constant high", int'(allOk), 1);
    // R1: duty 0 gives a constant low output (taken at the next boundary)
    duty[3*CW +: CW] = '0;
    repeat (10) @(negedge clk);
    allOk = 1;
    repeat (30) begin @(negedge clk); if (pwmOut[3]) allOk = 0; end
    check(allOk, "R1 duty zero constant low", int'(allOk), 1);

    // R4: a mid-period rewrite waits for the period boundary
    setChan(0, 2'b00, 20, 10);
    waitRise(0);
    duty[0 +: CW] = 8'd2;
    period[0 +: CW] = 8'd8;
    repeat (5) @(negedge clk);
    check(pwmOut[0] == 1'b1, "R4 old duty kept mid-period", int'(pwmOut[0]), 1);
    expectWave(0, 2, 8, "R4 new values after boundary");

    // R3: disable mid-period, restart must clear the count
    waitRise(0);
    @(negedge clk);
    chEn[0] = 1'b0;
    #1;
    check(pwmOut[0] == 1'b0, "R3 disabled output low", int'(pwmOut[0]), 0);
    period[0 +: CW] = 8'd20;
    duty[0 +: CW] = 8'd7;
    repeat (3) @(negedge clk);
    chEn[0] = 1'b1;
    #1;
    check(pwmOut[0] == 1'b1, "R3 high right after enable", int'(pwmOut[0]), 1);
    // count 0 is seen now; the following clock edges show counts 1..6 high
    h = 0;
    @(negedge clk);
    while (pwmOut[0]) begin h++; @(negedge clk); end
    check(h == 6, "R3 first high phase after restart", h, 6);

    // R8: join channels 0 and 1, period 300, duty 100, ruled by channel 1 fields
    @(negedge clk);
    chEn = '0;
    joinPair = 2'b01;
    preSelB = 3'd3;
    chSrc[1:0] = 2'b01;
    chSrc[3:2] = 2'b00;
    period[0 +: CW] = 8'h01; period[CW +: CW] = 8'h2C;
    duty[0 +: CW]   = 8'h00; duty[CW +: CW]   = 8'h64;
    @(negedge clk);
    chEn[1:0] = 2'b11;
    expectWave(1, 100, 300, "R8 joined 16-bit pair");
    check(pwmOut[0] == 1'b0, "R8 upper-byte pin low", int'(pwmOut[0]), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule